// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous memory that serves bursts of up to four beats from a single start address. A load edge (load/advance control low) with the chip selected captures the full start address and the write/read intent, and opens a burst at beat 0. Each later advance edge (control high) steps an internal two-bit beat counter. While it advances, the chip-select and write-enable inputs are disregarded.

The address bits above bit 1 come straight from the captured start address and never change during a burst. The two low bits follow one of two orders, chosen by a static order input. The linear order counts up and wraps modulo 4. The interleaved order XORs the start value with the beat count. The block raises a flag while the fourth beat is presented. It pulses an overrun flag for one cycle when an advance arrives after the fourth beat; the counter then wraps to the start value. A clock enable freezes all state.

Top module: `burst_addr_seq`

## Requirements
- R1: On an enabled edge (clkEn=1) with advLd=0 and chipSel=1, the block captures startAddr and writeEn. After that edge, burstActive=1, curAddr equals startAddr and curWrite equals the captured writeEn.
- R2: On an enabled edge with advLd=0 and chipSel=0, the block leaves the burst: burstActive=0 and the beat count returns to 0. The stored base address and curWrite are unchanged.
- R3: On an enabled edge with advLd=1 while burstActive=1, the beat count increments by one. The values of chipSel and writeEn have no effect on that edge: burstActive stays 1 and curWrite keeps its captured value.
- R4: When orderSel=0 (linear), curAddr[1:0] equals (start[1:0] + beat) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R5: When orderSel=1 (interleaved), curAddr[1:0] equals start[1:0] XOR beat. For example, a start of 10 gives 10, 11, 00, 01.
- R6: curAddr[ADDR_W-1:2] equals the captured start address for the whole burst. No carry passes out of bit 1.
- R7: lastBeat is 1 exactly when burstActive=1 and the beat count is 3.
- R8: An advance at beat 3 wraps the beat count to 0, so curAddr returns to the start address. The same edge makes burstOverrun 1 for exactly one cycle.
- R9: An advance while burstActive=0 has no effect: curAddr, burstActive and curWrite are unchanged and burstOverrun stays 0.
- R10: A synchronous reset (rst=1) gives burstActive=0, curAddr=0, curWrite=0, lastBeat=0 and burstOverrun=0.
- R11: An edge with clkEn=0 leaves curAddr, burstActive and curWrite unchanged and clears burstOverrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clkEn | input | 1 | Clock enable; 0 freezes state |
| advLd | input | 1 | 0 = load start address, 1 = advance burst |
| chipSel | input | 1 | Chip select, sampled only on load edges |
| writeEn | input | 1 | Write intent, sampled only on load edges |
| startAddr | input | ADDR_W | Full start address |
| orderSel | input | 1 | 0 = linear order, 1 = interleaved order |
| curAddr | output | ADDR_W | Current beat address |
| curWrite | output | 1 | Write intent held for the burst |
| burstActive | output | 1 | A burst is open |
| lastBeat | output | 1 | Fourth beat is being presented |
| burstOverrun | output | 1 | One-cycle pulse on an advance past the fourth beat |

## Verification
Several behaviours are checked by assertions on every cycle:
- the beat increments on each active advance;
- an idle advance changes nothing;
- the upper address bits and the write flag hold between loads;
- the overrun flag never lasts two cycles;
- a disabled clock freezes state.

Other behaviours only the bench scenarios can show:
- the exact linear and interleaved low-bit sequences from the different start values;
- the wrap back to the start address after the fourth beat;
- the carry-free step from 11 to 00 under a non-zero upper address;
- deselect and reset in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W      = 2;
  localparam int BURST_BEATS = 1 << BEAT_W;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } orderMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;
    logic [BEAT_W-1:0] beat;
  } seqStrobe_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clkEn,
  input  logic       advLd,
  input  logic       chipSel,
  output seqStrobe_t strobe,
  output logic       burstActive,
  output logic       lastBeat,
  output logic       burstOverrun
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);

  logic [BEAT_W-1:0] beatCnt;
  logic              loadStb, deselStb, stepStb, wrapStb;

  always_comb begin
    loadStb  = clkEn && !advLd && chipSel;
    deselStb = clkEn && !advLd && !chipSel;
    stepStb  = clkEn && advLd && burstActive;
    wrapStb  = stepStb && (beatCnt == LAST_BEAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burstActive  <= 1'b0;
      beatCnt      <= '0;
      burstOverrun <= 1'b0;
    end else begin
      burstOverrun <= wrapStb;
      if (loadStb) begin
        burstActive <= 1'b1;
        beatCnt     <= '0;
      end else if (deselStb) begin
        burstActive <= 1'b0;
        beatCnt     <= '0;
      end else if (stepStb) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  assign lastBeat       = burstActive && (beatCnt == LAST_BEAT);
  assign strobe.capture = loadStb;
  assign strobe.beat    = beatCnt;

  // R1
  load_open_chk: assert property (@(posedge clk) disable iff (rst)
    (clkEn && !advLd && chipSel) |=> (burstActive && strobe.beat == '0));

  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (clkEn && advLd && burstActive) |=>
      (burstActive && strobe.beat == BEAT_W'($past(strobe.beat) + 1'b1)));

  // R9
  idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (clkEn && advLd && !burstActive) |=>
      (!burstActive && !burstOverrun && $stable(strobe.beat)));

  // R8
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    burstOverrun |=> !burstOverrun);

  // R11
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> ($stable(strobe.beat) && $stable(burstActive) && !burstOverrun));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              writeEn,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] curAddr,
  output logic              curWrite
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseReg;
  logic [BEAT_W-1:0] lowBits;
  orderMode_e        orderMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg  <= '0;
      curWrite <= 1'b0;
    end else if (strobe.capture) begin
      baseReg  <= startAddr;
      curWrite <= writeEn;
    end
  end

  assign orderMode = orderMode_e'(orderSel);

  always_comb begin
    unique case (orderMode)
      ORDER_LINEAR: lowBits = baseReg[BEAT_W-1:0] + strobe.beat;
      ORDER_XOR:    lowBits = baseReg[BEAT_W-1:0] ^ strobe.beat;
      default:      lowBits = baseReg[BEAT_W-1:0];
    endcase
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign curAddr = {baseReg[ADDR_W-1:BEAT_W], lowBits};
    end else begin : g_noUpper
      assign curAddr = lowBits;
    end
  endgenerate

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(curAddr >> BEAT_W));

  // R3
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(curWrite));

  // R1
  capture_addr_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> (curAddr == $past(startAddr)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic              advLd,
  input  logic              chipSel,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] curAddr,
  output logic              curWrite,
  output logic              burstActive,
  output logic              lastBeat,
  output logic              burstOverrun
);
  seqStrobe_t strobe;

  burst_seq_ctrl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .clkEn        (clkEn),
    .advLd        (advLd),
    .chipSel      (chipSel),
    .strobe       (strobe),
    .burstActive  (burstActive),
    .lastBeat     (lastBeat),
    .burstOverrun (burstOverrun)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .startAddr (startAddr),
    .writeEn   (writeEn),
    .orderSel  (orderSel),
    .curAddr   (curAddr),
    .curWrite  (curWrite)
  );

  // R7
  last_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (lastBeat && clkEn && advLd) |=> (burstOverrun && !lastBeat));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clkEn = 1'b0;
  logic              advLd = 1'b0;
  logic              chipSel = 1'b0;
  logic              writeEn = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic              orderSel = 1'b0;
  logic [ADDR_W-1:0] curAddr;
  logic              curWrite, burstActive, lastBeat, burstOverrun;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .clkEn(clkEn), .advLd(advLd), .chipSel(chipSel),
    .writeEn(writeEn), .startAddr(startAddr), .orderSel(orderSel),
    .curAddr(curAddr), .curWrite(curWrite), .burstActive(burstActive),
    .lastBeat(lastBeat), .burstOverrun(burstOverrun)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic              act;
    logic              last;
    logic              over;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // reference model state
  logic              mAct = 1'b0;
  logic [1:0]        mBeat = '0;
  logic [ADDR_W-1:0] mBase = '0;
  logic              mWr = 1'b0;
  logic              mOver = 1'b0;

  task automatic drive(input logic r, input logic ce, input logic adv,
                       input logic cs, input logic we,
                       input logic [ADDR_W-1:0] sa, input logic ord,
                       input string tag);
    expItem_t e;
    logic [1:0] lo;
    @(negedge clk);
    rst = r; clkEn = ce; advLd = adv; chipSel = cs; writeEn = we;
    startAddr = sa; orderSel = ord;
    if (r) begin
      mAct = 0; mBeat = 0; mBase = '0; mWr = 0; mOver = 0;
    end else if (!ce) begin
      mOver = 0;
    end else if (!adv) begin
      mOver = 0;
      mBeat = 0;
      if (cs) begin mAct = 1; mBase = sa; mWr = we; end
      else mAct = 0;
    end else if (mAct) begin
      mOver = (mBeat == 2'd3);
      mBeat = mBeat + 2'd1;
    end else begin
      mOver = 0;
    end
    lo = ord ? (mBase[1:0] ^ mBeat) : (mBase[1:0] + mBeat);
    e.addr = {mBase[ADDR_W-1:2], lo};
    e.wr = mWr;
    e.act = mAct;
    e.last = mAct && (mBeat == 2'd3);
    e.over = mOver;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compares after each edge, away from it
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      testsRun++;
      if (curAddr !== e.addr || curWrite !== e.wr || burstActive !== e.act ||
          lastBeat !== e.last || burstOverrun !== e.over) begin
        testsFailed++;
        $display("FAIL %s: got addr=%h wr=%b act=%b last=%b ovr=%b, expected addr=%h wr=%b act=%b last=%b ovr=%b",
                 e.tag, curAddr, curWrite, burstActive, lastBeat, burstOverrun,
                 e.addr, e.wr, e.act, e.last, e.over);
      end
    end
  end

  initial begin
    // R10 reset state
    drive(1, 0, 0, 0, 0, 20'h0, 0, "R10 reset");
    drive(1, 1, 1, 1, 1, 20'hFFFFF, 1, "R10 reset held");
    // R1 load, linear R4, R3 ignored controls, R7 last beat
    drive(0, 1, 0, 1, 1, 20'h12341, 0, "R1 load start 01");
    drive(0, 1, 1, 0, 0, 20'h55555, 0, "R3 R4 beat1 low 10");
    drive(0, 1, 1, 1, 0, 20'hAAAAA, 0, "R3 R4 beat2 low 11");
    drive(0, 1, 1, 0, 0, 20'h00000, 0, "R4 R7 beat3 low 00 last");
    // R8 wrap and overrun pulse
    drive(0, 1, 1, 0, 0, 20'h00000, 0, "R8 wrap to start with overrun");
    drive(0, 1, 1, 0, 0, 20'h00000, 0, "R8 overrun single cycle");
    // R11 clock enable low
    drive(0, 0, 0, 1, 0, 20'h77777, 0, "R11 hold with clkEn low");
    drive(0, 0, 1, 0, 0, 20'h77777, 0, "R11 hold again");
    // R2 deselect, R9 idle advance
    drive(0, 1, 0, 0, 0, 20'h99999, 0, "R2 deselect");
    drive(0, 1, 1, 1, 0, 20'h33333, 0, "R9 idle advance");
    drive(0, 1, 1, 1, 1, 20'h44444, 0, "R9 idle advance again");
    // R5 interleaved from 10
    drive(0, 1, 0, 1, 0, 20'hABCD2, 1, "R5 load start 10");
    drive(0, 1, 1, 1, 1, 20'h0, 1, "R5 beat1 low 11");
    drive(0, 1, 1, 0, 1, 20'h0, 1, "R5 beat2 low 00");
    drive(0, 1, 1, 0, 0, 20'h0, 1, "R5 R7 beat3 low 01");
    drive(0, 1, 1, 0, 0, 20'h0, 1, "R5 R8 wrap interleaved");
    // R6 no carry out of bit 1
    drive(0, 1, 0, 1, 1, 20'h00FF3, 0, "R6 load start 11");
    drive(0, 1, 1, 0, 0, 20'h0, 0, "R6 step 11 to 00 no carry");
    drive(0, 1, 1, 0, 0, 20'h0, 1, "R5 R6 switch to interleaved beat2");
    // R10 reset mid burst
    drive(1, 1, 1, 0, 0, 20'h0, 0, "R10 reset mid burst");
    drive(0, 1, 1, 0, 0, 20'h0, 0, "R9 R10 advance after reset");
    repeat (3) @(posedge clk);
    #3;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL scoreboard: got %0d pending items, expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule